// File: doc/BRIEF.md
# Byte Logic and Rotate Unit

This block is the byte-wide Boolean and shift slice of a small 8-bit controller datapath. Each cycle it may accept an operation code, the accumulator byte, a second operand byte and the present carry flag. It computes a bitwise AND, OR or XOR, a complement, a clear, one of four rotates, or a nibble exchange. It then returns the new byte, the next carry value and a strobe that says whether the carry should be written.

Results are captured in an output register on the rising clock edge whenever the input is marked valid. They appear with an output valid flag one cycle after issue. Operand fetch, address decode, memory write-back and the other status flags belong to neighbouring logic.

Top module: `byte_logic_unit`

## Requirements
- R1: Code 0h gives acc AND opnd, code 1h gives acc OR opnd, and code 2h gives acc XOR opnd. Each is bitwise, combining same-position bits, so FFh AND 77h gives 77h.
- R2: Code 3h returns the bitwise inverse of acc, so 77h gives 88h. Code 4h returns 00h.
- R3: Code 5h rotates acc left by one, with old bit 7 landing in bit 0. Code 7h rotates acc right by one, with old bit 0 landing in bit 7. Neither one writes carry (`carry_wr` = 0).
- R4: Code 6h shifts acc left with the old carry entering bit 0, and old bit 7 becomes `carry_out`. Code 8h shifts acc right with the old carry entering bit 7, and old bit 0 becomes `carry_out`. Both raise `carry_wr`.
- R5: Code 9h exchanges bits 7..4 with bits 3..0 of acc.
- R6: For codes 0h to 5h, 7h and 9h, `carry_wr` is 0 and `carry_out` equals the issued `carry_in`.
- R7: Codes Ah to Fh return acc unchanged, with `carry_wr` = 0 and `carry_out` equal to `carry_in`.
- R8: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. When `in_valid` is low, `result`, `carry_out` and `carry_wr` keep their values.
- R9: After a synchronous active-high reset, `out_valid`, `carry_wr`, `carry_out` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Second operand byte |
| carry_in | input | 1 | Present carry flag |
| out_valid | output | 1 | Registered result is fresh |
| result | output | 8 | Registered result byte |
| carry_out | output | 1 | Registered next carry value |
| carry_wr | output | 1 | Registered carry-write strobe |

## Verification
The case hardest to bring about from the ports is a carry that must survive untouched. That happens when an operation that writes no carry follows one that did, or when idle cycles sit between issues and the registers must hold. The stimulus sweeps every accumulator value against every code, with a spread of operand bytes and both carry values. It alternates carry_in so that a stale carry would show, and it inserts idle cycles after carry-writing rotates to check that the outputs stay frozen.

// File: rtl/byte_logic_unit.sv
module byte_logic_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         carry_wr
);
  localparam int H = W / 2;

  typedef enum logic [3:0] {
    OP_AND  = 4'h0,
    OP_OR   = 4'h1,
    OP_XOR  = 4'h2,
    OP_INV  = 4'h3,
    OP_ZERO = 4'h4,
    OP_ROL  = 4'h5,
    OP_ROLC = 4'h6,
    OP_ROR  = 4'h7,
    OP_RORC = 4'h8,
    OP_NSWP = 4'h9
  } op_e;

  logic [W-1:0] nxt_res;
  logic         nxt_cy;
  logic         nxt_wr;

  always_comb begin
    nxt_res = acc_in;
    nxt_cy  = carry_in;
    nxt_wr  = 1'b0;
    case (op)
      OP_AND:  nxt_res = acc_in & opnd_in;
      OP_OR:   nxt_res = acc_in | opnd_in;
      OP_XOR:  nxt_res = acc_in ^ opnd_in;
      OP_INV:  nxt_res = ~acc_in;
      OP_ZERO: nxt_res = '0;
      OP_ROL:  nxt_res = {acc_in[W-2:0], acc_in[W-1]};
      OP_ROR:  nxt_res = {acc_in[0], acc_in[W-1:1]};
      OP_ROLC: begin
        nxt_res = {acc_in[W-2:0], carry_in};
        nxt_cy  = acc_in[W-1];
        nxt_wr  = 1'b1;
      end
      OP_RORC: begin
        nxt_res = {carry_in, acc_in[W-1:1]};
        nxt_cy  = acc_in[0];
        nxt_wr  = 1'b1;
      end
      OP_NSWP: nxt_res = {acc_in[H-1:0], acc_in[W-1:H]};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      carry_wr  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        carry_out <= nxt_cy;
        carry_wr  <= nxt_wr;
      end
    end
  end
endmodule

// File: rtl/byte_logic_unit_chk.sv
module byte_logic_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opnd_in,
  input logic         carry_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         carry_wr
);
  p_reset_r9: assert property (@(posedge clk) rst |=> !out_valid && !carry_wr && result == '0);

  p_valid_r8: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result) && $stable(carry_out) && $stable(carry_wr));

  p_and_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h0 |=> result == ($past(acc_in) & $past(opnd_in)));

  p_clr_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h4 |=> result == '0);

  p_rol_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h5 |=> result[0] == $past(acc_in[W-1]) && !carry_wr);

  p_rolc_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h6 |=> carry_wr && carry_out == $past(acc_in[W-1]) && result[0] == $past(carry_in));

  p_rorc_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h8 |=> carry_wr && carry_out == $past(acc_in[0]) && result[W-1] == $past(carry_in));

  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'h9 |=> $countones(result) == $countones($past(acc_in)));

  p_noflag_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && op != 4'h6 && op != 4'h8 |=> !carry_wr && carry_out == $past(carry_in));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && op >= 4'hA |=> result == $past(acc_in));
endmodule

bind byte_logic_unit byte_logic_unit_chk #(.W(W)) chk_i (.*);

// File: tb/byte_logic_unit_tb_top.sv
module byte_logic_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] result;
  logic       carry_out;
  logic       carry_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_logic_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .acc_in(acc_in),
    .opnd_in(opnd_in), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .carry_wr(carry_wr)
  );

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'h0, 4'h1, 4'h2: return "R1/R6";
      4'h3, 4'h4:       return "R2/R6";
      4'h5, 4'h7:       return "R3/R6";
      4'h6, 4'h8:       return "R4";
      4'h9:             return "R5/R6";
      default:          return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got v/wr/cy/res=%h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic c);
    int ai;
    int er;
    logic ec;
    logic ew;
    ai = int'(a);
    ec = c;
    ew = 1'b0;
    case (o)
      4'h0: er = int'(a & b);
      4'h1: er = int'(a | b);
      4'h2: er = int'(a ^ b);
      4'h3: er = 255 - ai;
      4'h4: er = 0;
      4'h5: er = (ai * 2) % 256 + ai / 128;
      4'h6: begin er = (ai * 2) % 256 + int'(c); ec = (ai >= 128); ew = 1'b1; end
      4'h7: er = ai / 2 + (ai % 2) * 128;
      4'h8: begin er = ai / 2 + int'(c) * 128; ec = (ai % 2 == 1); ew = 1'b1; end
      4'h9: er = (ai % 16) * 16 + ai / 16;
      default: er = ai;
    endcase
    op = o; acc_in = a; opnd_in = b; carry_in = c; in_valid = 1'b1;
    @(negedge clk);
    check(tag(o), {out_valid, carry_wr, carry_out, result}, {1'b1, ew, ec, 8'(er)});
  endtask

  initial begin
    logic [10:0] snap;
    repeat (3) @(negedge clk);
    check("R9", {out_valid, carry_wr, carry_out, result}, 11'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle", {10'd0, out_valid}, 11'd0);

    run_op(4'h0, 8'hFF, 8'h77, 1'b0);
    run_op(4'h3, 8'h77, 8'h00, 1'b1);
    run_op(4'h6, 8'h80, 8'h00, 1'b0);
    snap = {out_valid, carry_wr, carry_out, result};
    in_valid = 1'b0;
    op = 4'h4; acc_in = 8'h5A; carry_in = 1'b0;
    @(negedge clk);
    check("R8 hold", {1'b1, carry_wr, carry_out, result}, snap);
    check("R8 valid", {10'd0, out_valid}, 11'd0);
    run_op(4'h3, 8'h12, 8'h00, 1'b1);

    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          run_op(4'(o), 8'(a), 8'(k * 37 + 5), 1'((a + k) % 2));

    for (int o = 0; o < 16; o++) begin
      run_op(4'(o), 8'hA5, 8'h3C, 1'b1);
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 gap", {10'd0, out_valid}, 11'd0);
    end

    rst = 1'b1;
    @(negedge clk);
    check("R9 mid", {out_valid, carry_wr, carry_out, result}, 11'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule